// File: doc/BRIEF.md
# Partitioned Distributed-Arithmetic FIR Filter

This block is an FIR filter that uses no multipliers. Each accepted input sample enters a tap delay line. The filter then forms the new output over one clock per input bit, least significant bit first. On each bit cycle it takes the bit of that significance from every tap. The taps are split into fixed-size groups. Each group's bits address a small table of precomputed coefficient sums for that group. The table outputs are added together, weighted by the bit position, and folded into a scaling accumulator.

The coefficients are signed elaboration-time parameters, and every table is generated from them when the design is elaborated. A parameter selects how the input word is read: as an unsigned value, or as a two's-complement value. In two's-complement mode the table sum taken on the most significant bit cycle is subtracted instead of added. The filter takes a new sample only when it is idle and reports each result with a one-cycle strobe.

Top module: `da_fir_filter`

## Requirements
- R1: While reset is held and after it is released, `ready_o` is 1, `y_valid_o` is 0 and `y_o` is 0.
- R2: A sample is accepted on a rising clock edge where `sample_valid_i` and `ready_o` are both 1. `ready_o` is 0 from the following cycle until the result is delivered.
- R3: A sample offered while `ready_o` is 0 is ignored. It does not enter the delay line and does not change any later result.
- R4: `y_valid_o` rises DATA_W clock edges after the accepting edge and stays high for exactly one cycle.
- R5: In unsigned mode, `y_o` equals the sum over k of h_k * x(n-k). Here x(n) is the newest accepted sample in tap 0, the taps hold 0 after reset, and h_k is bits [k*COEF_W +: COEF_W] of COEFS, read as a signed value.
- R6: Within a group of GROUP_W taps, table address bit GROUP_W-1-j selects tap (group*GROUP_W + j). Each table word is the sum of the coefficients whose address bit is 1, so a word at address 0 is 0. With unequal coefficients, the taps pair with the right coefficients.
- R7: In two's-complement mode (SIGNED_IN=1), each input sample counts as a signed DATA_W-bit value. Sample 8 therefore counts as -8 at DATA_W=4.
- R8: With four taps, all coefficients equal to 1, and unsigned inputs 11, 13, 10 and 9 applied after reset, the fourth result is 43.
- R9: `y_o` keeps its value between result strobes.
- R10: The result is exact at the extreme inputs, all taps at 15 (unsigned) or all at -8 (signed), with no overflow.
- R11: The result does not depend on GROUP_W. Groups of 1, 2 and 4 taps all give the same output for the same coefficients.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | DATA_W | Input sample |
| sample_valid_i | input | 1 | Sample offered |
| ready_o | output | 1 | Filter idle, so a sample can be accepted |
| y_o | output | ACC_W | Signed filter result |
| y_valid_o | output | 1 | One-cycle result strobe |

## Verification
The hardest case to reach is a sample offered in the middle of a bit-serial computation. The bench pulses `sample_valid_i` with an unrelated value right after every second acceptance. Because the bench's own tap history never includes that value, any leak into the delay line shows up in a later result. The sign-weighted most significant bit cycle and the widest sums come from runs of identical extreme samples that fill every tap. Four instances share one input stream: unsigned, signed, single-table and one-tap-group. This lets the partitioning be compared against a single table.

// File: rtl/da_fir_pkg.sv
package da_fir_pkg;
  function automatic int acc_width(int coef_w, int data_w, int taps);
    return coef_w + data_w + $clog2(taps) + 1;
  endfunction

  function automatic int idx_width(int data_w);
    return (data_w > 1) ? $clog2(data_w) : 1;
  endfunction
endpackage

// File: rtl/da_fir_tap_line.sv
module da_fir_tap_line #(
  parameter int NUM_TAPS = 4,
  parameter int DATA_W   = 4,
  parameter int IDX_W    = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                shift_i,
  input  logic [DATA_W-1:0]   sample_i,
  input  logic [IDX_W-1:0]    bit_sel_i,
  output logic [NUM_TAPS-1:0] bits_o
);
  logic [DATA_W-1:0] taps_q [NUM_TAPS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_TAPS; k++) taps_q[k] <= '0;
    end else if (shift_i) begin
      taps_q[0] <= sample_i;
      for (int k = 1; k < NUM_TAPS; k++) taps_q[k] <= taps_q[k-1];
    end
  end

  for (genvar k = 0; k < NUM_TAPS; k++) begin : g_bit
    assign bits_o[k] = taps_q[k][bit_sel_i];
  end
endmodule

// File: rtl/da_fir_part_rom.sv
module da_fir_part_rom #(
  parameter int GROUP_W = 2,
  parameter int COEF_W  = 8,
  parameter int ACC_W   = 15,
  parameter logic [GROUP_W*COEF_W-1:0] GCOEFS = '0
) (
  input  logic [GROUP_W-1:0]       addr_i,
  output logic signed [ACC_W-1:0]  word_o
);
  localparam int DEPTH = 2 ** GROUP_W;

  function automatic logic signed [ACC_W-1:0] word_for(int a);
    logic signed [ACC_W-1:0] s;
    s = '0;
    // address MSB pairs with the group's lowest-index tap
    for (int j = 0; j < GROUP_W; j++)
      if (a[GROUP_W-1-j]) s = s + ACC_W'($signed(GCOEFS[j*COEF_W +: COEF_W]));
    return s;
  endfunction

  logic signed [ACC_W-1:0] tbl [DEPTH];

  for (genvar a = 0; a < DEPTH; a++) begin : g_word
    localparam logic signed [ACC_W-1:0] WORD = word_for(a);
    assign tbl[a] = WORD;
  end

  assign word_o = tbl[addr_i];
endmodule

// File: rtl/da_fir_scale_acc.sv
module da_fir_scale_acc #(
  parameter int ACC_W     = 15,
  parameter int IDX_W     = 2,
  parameter bit SIGNED_IN = 1'b0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    first_i,
  input  logic                    last_i,
  input  logic [IDX_W-1:0]        bit_idx_i,
  input  logic signed [ACC_W-1:0] sum_i,
  output logic signed [ACC_W-1:0] next_o
);
  logic signed [ACC_W-1:0] acc_q, term, base;

  always_comb begin
    term = sum_i <<< bit_idx_i;
    base = first_i ? '0 : acc_q;
    if (SIGNED_IN && last_i) next_o = base - term;  // sign bit has negative weight
    else                     next_o = base + term;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (step_i) acc_q <= next_o;
  end
endmodule

// File: rtl/da_fir_filter.sv
module da_fir_filter
  import da_fir_pkg::*;
#(
  parameter int NUM_TAPS  = 4,
  parameter int DATA_W    = 4,
  parameter int GROUP_W   = 2,
  parameter int COEF_W    = 8,
  parameter bit SIGNED_IN = 1'b0,
  parameter logic [NUM_TAPS*COEF_W-1:0] COEFS = 32'h02FD0507,
  localparam int ACC_W    = acc_width(COEF_W, DATA_W, NUM_TAPS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [DATA_W-1:0]       sample_i,
  input  logic                    sample_valid_i,
  output logic                    ready_o,
  output logic signed [ACC_W-1:0] y_o,
  output logic                    y_valid_o
);
  localparam int IDX_W    = idx_width(DATA_W);
  localparam int N_GROUPS = NUM_TAPS / GROUP_W;
  localparam int GBITS    = GROUP_W * COEF_W;

  logic                busy_q;
  logic [IDX_W-1:0]    bit_idx_q;
  logic                accept, first_bit, last_bit;
  logic [NUM_TAPS-1:0] tap_bits;
  logic signed [ACC_W-1:0] part_word [N_GROUPS];
  logic signed [ACC_W-1:0] part_sum, acc_next;

  assign ready_o   = !busy_q;
  assign accept    = sample_valid_i && !busy_q;
  assign first_bit = (bit_idx_q == '0);
  assign last_bit  = (bit_idx_q == IDX_W'(DATA_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      bit_idx_q <= '0;
    end else if (accept) begin
      busy_q    <= 1'b1;
      bit_idx_q <= '0;
    end else if (busy_q) begin
      if (last_bit) busy_q <= 1'b0;
      else          bit_idx_q <= bit_idx_q + 1'b1;
    end
  end

  da_fir_tap_line #(.NUM_TAPS(NUM_TAPS), .DATA_W(DATA_W), .IDX_W(IDX_W)) i_taps (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (accept),
    .sample_i  (sample_i),
    .bit_sel_i (bit_idx_q),
    .bits_o    (tap_bits)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_part
    logic [GROUP_W-1:0] addr;
    for (genvar j = 0; j < GROUP_W; j++) begin : g_addr
      assign addr[GROUP_W-1-j] = tap_bits[g*GROUP_W + j];
    end
    da_fir_part_rom #(
      .GROUP_W (GROUP_W),
      .COEF_W  (COEF_W),
      .ACC_W   (ACC_W),
      .GCOEFS  (COEFS[g*GBITS +: GBITS])
    ) i_rom (
      .addr_i (addr),
      .word_o (part_word[g])
    );
  end

  always_comb begin
    part_sum = '0;
    for (int g = 0; g < N_GROUPS; g++) part_sum = part_sum + part_word[g];
  end

  da_fir_scale_acc #(.ACC_W(ACC_W), .IDX_W(IDX_W), .SIGNED_IN(SIGNED_IN)) i_acc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (busy_q),
    .first_i   (first_bit),
    .last_i    (last_bit),
    .bit_idx_i (bit_idx_q),
    .sum_i     (part_sum),
    .next_o    (acc_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_o       <= '0;
      y_valid_o <= 1'b0;
    end else begin
      y_valid_o <= busy_q && last_bit;
      if (busy_q && last_bit) y_o <= acc_next;
    end
  end
endmodule

// File: rtl/da_fir_checker.sv
module da_fir_checker #(
  parameter int DATA_W = 4,
  parameter int ACC_W  = 15
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sample_valid_i,
  input logic             ready_o,
  input logic [ACC_W-1:0] y_o,
  input logic             y_valid_o
);
  logic [15:0] since_acc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         since_acc <= '0;
    else if (sample_valid_i && ready_o)  since_acc <= 16'd1;
    else if (y_valid_o)                  since_acc <= '0;
    else if (since_acc != '0)            since_acc <= since_acc + 16'd1;
  end

  AST_ACCEPT_BLOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_valid_i && ready_o) |=> !ready_o);  // R2
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (since_acc != '0 && !y_valid_o) |-> !ready_o);  // R3
  AST_STROBE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |-> (since_acc == 16'(DATA_W + 1)));  // R4
  AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    y_valid_o |=> !y_valid_o);  // R4
  AST_RESULT_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(y_o) |-> y_valid_o);  // R9
endmodule

bind da_fir_filter da_fir_checker #(.DATA_W(DATA_W), .ACC_W(ACC_W)) i_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sample_valid_i (sample_valid_i),
  .ready_o        (ready_o),
  .y_o            (y_o),
  .y_valid_o      (y_valid_o)
);

// File: tb/test_da_fir_filter.sv
module test_da_fir_filter;
  localparam logic [31:0] CF   = 32'h02FD0507;  // h0=7 h1=5 h2=-3 h3=2
  localparam logic [31:0] ONES = 32'h01010101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] smp = '0;
  logic vld = 1'b0;
  logic rdy_a, rdy_b, rdy_c, rdy_d, yv_a, yv_b, yv_c, yv_d;
  logic signed [14:0] y_a, y_b, y_c, y_d;
  int total = 0, bad = 0;
  bit done = 0;
  int hist [4] = '{0, 0, 0, 0};
  int hc [4] = '{7, 5, -3, 2};

  always #2.5 clk = ~clk;

  da_fir_filter #(.GROUP_W(2), .SIGNED_IN(0), .COEFS(CF)) i_da_fir_filter (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .sample_valid_i(vld),
    .ready_o(rdy_a), .y_o(y_a), .y_valid_o(yv_a));
  da_fir_filter #(.GROUP_W(2), .SIGNED_IN(1), .COEFS(CF)) i_da_fir_filter_s (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .sample_valid_i(vld),
    .ready_o(rdy_b), .y_o(y_b), .y_valid_o(yv_b));
  da_fir_filter #(.GROUP_W(4), .SIGNED_IN(0), .COEFS(CF)) i_da_fir_filter_g4 (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .sample_valid_i(vld),
    .ready_o(rdy_c), .y_o(y_c), .y_valid_o(yv_c));
  da_fir_filter #(.GROUP_W(1), .SIGNED_IN(0), .COEFS(ONES)) i_da_fir_filter_one (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .sample_valid_i(vld),
    .ready_o(rdy_d), .y_o(y_d), .y_valid_o(yv_d));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int expect_y(input bit sgn, input bit ones);
    int s = 0;
    for (int k = 0; k < 4; k++) begin
      int xv = (sgn && hist[k] >= 8) ? hist[k] - 16 : hist[k];
      s += (ones ? 1 : hc[k]) * xv;
    end
    return s;
  endfunction

  task automatic send(input logic [3:0] x, input bit inject, input string tag);
    int n = 0;
    int ea, eb, ed, held;
    @(negedge clk);
    smp = x; vld = 1'b1;
    @(negedge clk);
    vld = 1'b0;
    for (int k = 3; k > 0; k--) hist[k] = hist[k-1];
    hist[0] = int'(x);
    chk(!rdy_a && !rdy_b && !rdy_c && !rdy_d, "R2 ready low while busy", int'(rdy_a), 0);
    if (inject) begin
      smp = ~x; vld = 1'b1;  // R3: must be ignored
      @(negedge clk); n++;
      vld = 1'b0;
      chk(!rdy_a, "R3 busy rejects sample", int'(rdy_a), 0);
    end
    while (!yv_a && n < 20) begin
      @(negedge clk); n++;
    end
    chk(n == 4, "R4 strobe latency", n, 4);
    ea = expect_y(0, 0); eb = expect_y(1, 0); ed = expect_y(0, 1);
    chk(int'(y_a) == ea, {"R5 R6 unsigned ", tag}, int'(y_a), ea);
    chk(int'(y_b) == eb, {"R7 signed ", tag}, int'(y_b), eb);
    chk(int'(y_c) == ea, {"R11 single table ", tag}, int'(y_c), ea);
    chk(yv_b && yv_c && yv_d && int'(y_d) == ed, {"R11 one-tap groups ", tag}, int'(y_d), ed);
    held = int'(y_a);
    @(negedge clk);
    chk(!yv_a, "R4 strobe one cycle", int'(yv_a), 0);
    chk(int'(y_a) == held && rdy_a, "R9 result held", int'(y_a), held);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rdy_a && !yv_a && y_a == 0, "R1 reset state in reset", int'(y_a), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdy_a && rdy_b && !yv_a && y_a == 0 && y_b == 0, "R1 reset state after", int'(y_a), 0);
    send(4'd11, 0, "ex"); send(4'd13, 1, "ex"); send(4'd10, 0, "ex"); send(4'd9, 1, "ex");
    chk(int'(y_d) == 43, "R8 worked example", int'(y_d), 43);
    for (int v = 0; v < 16; v++) send(4'(v), v[0], "sweep");
    for (int r = 0; r < 4; r++) send(4'd15, 0, "max");
    chk(int'(y_a) == 15 * 11, "R10 unsigned max", int'(y_a), 165);
    for (int r = 0; r < 4; r++) send(4'd8, r[0], "min");
    chk(int'(y_b) == -8 * 11, "R10 signed min", int'(y_b), -88);
    send(4'd1, 0, "imp"); send(4'd0, 0, "imp"); send(4'd0, 0, "imp"); send(4'd0, 0, "imp");
    chk(int'(y_a) == 2, "R6 last tap pairs with h3", int'(y_a), 2);
    for (int v = 15; v >= 0; v--) send(4'(v), 1, "down");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=0 exp=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule